// File: doc/BRIEF.md
# Serial Register Bank Target

This block lets an external host read and write a bank of byte-wide control registers over a four-wire synchronous serial link: a clock, a data input, an active-low select and a data output. Each access is one 16-bit frame sent most significant bit first. The frame carries a direction flag, then a register address, then a data byte. Internal logic reads any register at any time through a parallel observation port. That port is a plain address-in, data-out path with no flow control, because a register is always ready to be read.

The serial pins are oversampled by the block's own system clock. A two-stage synchronizer brings them into that clock domain. Rising and falling edges of the serial clock are then found by comparing the synchronized level with its value one cycle earlier. The input bit is taken on rising edges. Read data is launched on falling edges. The write to the register array happens on the sixteenth rising edge of a frame. Raising select at any point ends the frame, resets the bit position and drives the output high.

Top module: `spi_regbank`

## Requirements
- R1: A frame is 16 bits, most significant bit first. Bit 15 is the direction flag, bits 14..8 are the address A6..A0, and bits 7..0 are the data D7..D0. On the 16th rising edge of the serial clock, a write frame stores the data byte into the addressed register.
- R2: A direction flag of 1 marks a write. A direction flag of 0 marks a read, and a read frame changes no register.
- R3: The 7-bit address selects one of 128 independent 8-bit registers, from 0x00 to 0x7F.
- R4: In a read frame the trailing eight input bits are ignored, so every register keeps its value.
- R5: In a read frame, the addressed register appears on the output MSB first. One bit is launched on each of the eight falling edges that follow the 8th rising edge. Each bit is stable by the next rising edge.
- R6: After D0 of a read has been launched, the output keeps that level for as long as select stays low.
- R7: While select is high, and after reset, the output is logic 1. It returns to 1 within three system clock cycles of select rising.
- R8: Raising select before the 16th rising edge abandons the frame without any write. The next frame starts again at bit 15.
- R9: After reset every register holds 0x00.
- R10: The block works correctly when the high and low phases of the serial clock each last at least four system clock periods. This gives 10 MHz serial operation at a 125 MHz system clock.
- R11: The observation port returns the current contents of the register at its address in the same cycle.
- R12: Serial clock edges after the 16th within one select period cause no write and do not change the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_sdi | input | 1 | Serial data from host |
| spi_sel_n | input | 1 | Active-low frame select |
| spi_sdo | output | 1 | Serial data to host, high when idle |
| obs_addr | input | 7 | Observation port register address |
| obs_data | output | 8 | Observation port register contents |

## Verification
A wrong bit counter or a wrong captured header moves the read bits by one position, or sends a write to the wrong register. The observation port shows the wrong write within three system cycles of the last rising edge, and the host's captured byte shows the shifted read at the end of the frame. A fault in the output path is seen sooner. The output is compared on every system clock against a model delayed by the three-cycle synchronizer and edge latency, so a stuck, early, late or non-holding bit is reported in the cycle it first differs.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int RB_ADDR_W  = 7;
  localparam int RB_DATA_W  = 8;
  localparam int RB_SYNC_N  = 2;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } frame_phase_e;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [STAGES-1:0][W-1:0] stg_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= RST_VAL;
          else        stg_q[0] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign d_out = stg_q[STAGES-1];
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] obs_addr,
  output logic [DATA_W-1:0] obs_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data  = mem_q[rd_addr];
  assign obs_data = mem_q[obs_addr];

  // R1: a write strobe lands its byte in the addressed entry
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              desel_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo
);
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int SR_W       = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic                sclk_d_q;
  logic                rise, fall;
  logic [SR_W-2:0]     sr_q;
  logic [SR_W-1:0]     sr_next;
  logic [CNT_W-1:0]    cnt_q;
  frame_phase_e        phase_q;
  logic                rw_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   out_sr_q;
  logic                sdo_q;
  logic                hdr_done, frame_done;

  assign rise       = sclk_s & ~sclk_d_q;
  assign fall       = ~sclk_s & sclk_d_q;
  assign sr_next    = {sr_q, sdi_s};
  assign hdr_done   = rise && (phase_q == PH_HDR) && (cnt_q == CNT_W'(HDR_BITS - 1));
  assign frame_done = rise && (phase_q == PH_DATA) && (cnt_q == CNT_W'(FRAME_BITS - 1));

  assign rd_addr = sr_next[ADDR_W-1:0];
  assign wr_en   = frame_done && rw_q && !desel_s;
  assign wr_addr = addr_q;
  assign wr_data = sr_next[DATA_W-1:0];
  assign sdo     = sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d_q <= 1'b0;
    else        sclk_d_q <= sclk_s;
  end

  // bit position and frame phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_HDR;
      sr_q    <= '0;
      rw_q    <= 1'b0;
      addr_q  <= '0;
    end else if (desel_s) begin
      cnt_q   <= '0;
      phase_q <= PH_HDR;
    end else if (rise && phase_q != PH_DONE) begin
      cnt_q <= cnt_q + 1'b1;
      sr_q  <= sr_next[SR_W-2:0];
      if (hdr_done) begin
        phase_q <= PH_DATA;
        rw_q    <= sr_next[ADDR_W];
        addr_q  <= sr_next[ADDR_W-1:0];
      end
      if (frame_done) phase_q <= PH_DONE;
    end
  end

  // read data launch on falling edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q    <= 1'b1;
      out_sr_q <= '0;
    end else if (desel_s) begin
      sdo_q <= 1'b1;
    end else begin
      if (hdr_done && !sr_next[ADDR_W]) out_sr_q <= rd_data;
      if (fall && phase_q == PH_DATA && !rw_q) begin
        sdo_q    <= out_sr_q[DATA_W-1];
        out_sr_q <= {out_sr_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_BITS));
  p_read_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA && !rw_q) |-> !wr_en);
  p_sdo_only_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!desel_s && !fall) |=> $stable(sdo_q));
  p_hold_last_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!desel_s && phase_q == PH_DONE) |=> $stable(sdo_q));
  p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    desel_s |=> sdo_q);
  p_write_ends_frame_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (phase_q == PH_DONE));
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_rb_pkg::*;
#(
  parameter int ADDR_W = RB_ADDR_W,
  parameter int DATA_W = RB_DATA_W,
  parameter int SYNC_N = RB_SYNC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  input  logic              spi_sel_n,
  output logic              spi_sdo,
  input  logic [ADDR_W-1:0] obs_addr,
  output logic [DATA_W-1:0] obs_data
);
  logic [2:0]        pins_s;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  // bit order: {sclk, select_n, sdi}; select idles high
  spi_rb_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({spi_sclk, spi_sel_n, spi_sdi}),
    .d_out (pins_s)
  );

  spi_rb_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (pins_s[2]),
    .sdi_s   (pins_s[0]),
    .desel_s (pins_s[1]),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sdo     (spi_sdo)
  );

  spi_rb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .obs_addr (obs_addr),
    .obs_data (obs_data)
  );

  // R8: no write strobe while the synchronized select is high
  p_abort_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pins_s[1] |-> !wr_en);
endmodule

// File: tb/spi_regbank_tb_top.sv
module spi_regbank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b0;
  logic       spi_sdi = 1'b0;
  logic       spi_sel_n = 1'b1;
  logic       spi_sdo;
  logic [6:0] obs_addr = '0;
  logic [7:0] obs_data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model_mem [128];
  logic       exp_now = 1'b1;
  logic [2:0] exp_dly = 3'b111;
  bit         cmp_en = 1'b0;
  logic [7:0] got;

  always #4 clk = ~clk;

  spi_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_sdi(spi_sdi),
    .spi_sel_n(spi_sel_n), .spi_sdo(spi_sdo), .obs_addr(obs_addr), .obs_data(obs_data)
  );

  // model output delayed by synchronizer plus edge-detect latency
  always @(posedge clk) exp_dly <= {exp_dly[1:0], exp_now};

  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (spi_sdo !== exp_dly[2]) begin
        fails++;
        $display("FAIL R5 R6 R7 per-cycle sdo actual=%b expected=%b at %0t", spi_sdo, exp_dly[2], $time);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic obs_check(input logic [6:0] a, input string req);
    @(negedge clk);
    obs_addr = a;
    #1;
    check(obs_data === model_mem[a], req, obs_data, model_mem[a]);
  endtask

  task automatic spi_xfer(input bit rw, input logic [6:0] a, input logic [7:0] d,
                          input int nbits, input int hp, output logic [7:0] rd);
    logic [15:0] w;
    logic [7:0]  sh;
    w  = {rw, a, d};
    rd = '0;
    sh = '0;
    @(negedge clk);
    spi_sel_n = 1'b0;
    repeat (hp) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_sdi = (i < 16) ? w[15-i] : 1'b1;
      repeat (hp) @(negedge clk);
      spi_sclk = 1'b1;
      if (i >= 8 && i < 16) rd[15-i] = spi_sdo;
      if (i == 7 && !rw) sh = model_mem[a];
      if (i == 15 && rw) model_mem[a] = d;
      repeat (hp) @(negedge clk);
      spi_sclk = 1'b0;
      if (!rw && i >= 7 && i <= 14) begin
        exp_now = sh[7];
        sh = {sh[6:0], 1'b0};
      end
    end
    repeat (hp + 4) @(negedge clk);
    if (!rw && nbits >= 16)
      check(spi_sdo === model_mem[a][0], "R6 sdo holds D0 with select low", spi_sdo, model_mem[a][0]);
    spi_sel_n = 1'b1;
    exp_now = 1'b1;
    repeat (hp + 4) @(negedge clk);
    check(spi_sdo === 1'b1, "R7 sdo high after deselect", spi_sdo, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) model_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_en = 1'b1;

    // R9: all registers clear after reset
    for (int i = 0; i < 128; i++) obs_check(7'(i), "R9 reset value");
    check(spi_sdo === 1'b1, "R7 sdo after reset", spi_sdo, 1);

    // R1 R2 R3: writes at both address extremes and in between
    spi_xfer(1'b1, 7'h00, 8'hA5, 16, 4, got);
    spi_xfer(1'b1, 7'h7F, 8'h3C, 16, 4, got);
    spi_xfer(1'b1, 7'h2A, 8'h81, 16, 4, got);
    spi_xfer(1'b1, 7'h55, 8'hFF, 16, 4, got);
    spi_xfer(1'b1, 7'h01, 8'h5A, 16, 4, got);
    obs_check(7'h00, "R1 write 0x00");
    obs_check(7'h7F, "R3 write 0x7F");
    obs_check(7'h2A, "R2 write 0x2A");
    obs_check(7'h55, "R11 observe 0x55");
    obs_check(7'h01, "R3 neighbour 0x01");
    obs_check(7'h40, "R3 untouched 0x40");

    // R5 R10: reads at the fastest supported rate, trailing byte all ones
    spi_xfer(1'b0, 7'h00, 8'hFF, 16, 4, got);
    check(got === model_mem[0], "R5 R10 read 0x00", got, model_mem[0]);
    spi_xfer(1'b0, 7'h7F, 8'hFF, 16, 4, got);
    check(got === model_mem[127], "R5 R10 read 0x7F", got, model_mem[127]);
    spi_xfer(1'b0, 7'h2A, 8'h00, 16, 4, got);
    check(got === 8'h81, "R5 read 0x2A", got, 8'h81);
    obs_check(7'h00, "R4 read leaves 0x00");
    obs_check(7'h7F, "R2 R4 read leaves 0x7F");

    // slower serial clock
    spi_xfer(1'b0, 7'h01, 8'h33, 16, 7, got);
    check(got === 8'h5A, "R5 read 0x01 slow", got, 8'h5A);
    spi_xfer(1'b0, 7'h40, 8'hFF, 16, 7, got);
    check(got === 8'h00, "R9 R5 read unwritten", got, 8'h00);

    // R8: abandoned frames
    spi_xfer(1'b1, 7'h10, 8'h77, 15, 4, got);
    obs_check(7'h10, "R8 15-bit frame no write");
    spi_xfer(1'b0, 7'h55, 8'h00, 9, 4, got);
    spi_xfer(1'b1, 7'h10, 8'h12, 16, 4, got);
    obs_check(7'h10, "R8 frame after abort");
    obs_check(7'h55, "R8 aborted read keeps 0x55");

    // R12: extra serial clocks after bit 16
    spi_xfer(1'b1, 7'h20, 8'hC3, 20, 4, got);
    obs_check(7'h20, "R12 extra clocks write");
    spi_xfer(1'b0, 7'h20, 8'h00, 20, 5, got);
    check(got === 8'hC3, "R12 extra clocks read", got, 8'hC3);

    // R1: overwrite the top register
    spi_xfer(1'b1, 7'h7F, 8'h00, 16, 4, got);
    obs_check(7'h7F, "R1 overwrite 0x7F");
    obs_check(7'h00, "R3 0x00 unaffected");

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule